// File: doc/BRIEF.md
# Auto-Incrementing Lookup Table Loader

This block fills five on-chip lookup memories through one streaming data port. Software first writes a control word that picks a target table and a start index. After that, each write to the data port stores one word into the chosen table at the running index and then moves the index on by one. A long block of table contents can therefore be loaded with one control write followed by back-to-back data writes, without sending an address with each word.

The block contains three tables of 128 x 24 bits (noise, colour-function and alpha-function curves) and two tables of 256 x 32 bits (colour and colour difference). The 256-entry tables hold one byte per channel: red in bits 7:0, green in 15:8, blue in 23:16 and alpha in 31:24. Each table has its own read port for the datapath. A read port returns data on the cycle after the address is presented.

Top module: `lut_loader`

## Requirements
- R1: After reset the running index is 0 and the selector is 0, so a data write issued with no prior control write lands in entry 0 of the noise table.
- R2: A control write takes the start index from `ctl_wdata[7:0]` and the table selector from `ctl_wdata[11:8]`. Bits 31:12 have no effect.
- R3: Selector codes map as follows: 0 noise, 2 colour function, 3 alpha function, 4 colour, 5 colour difference.
- R4: Consecutive data writes store into consecutive entries of the selected table, starting at the start index.
- R5: The 24-bit tables store `dat_wdata[23:0]`. Data bits 31:24 are discarded.
- R6: The 32-bit tables store all 32 data bits unchanged, with red in bits 7:0, green in 15:8, blue in 23:16 and alpha in 31:24.
- R7: For a 128-entry table, the entry written is the index modulo 128, and the index after a write is (index+1) mod 128. For a 256-entry table, the index wraps from 255 to 0.
- R8: Under selector values 1 and 6 to 15, data writes are accepted but change no table, and the index still advances by one per write.
- R9: A control write reloads the running index with its start index. The reload replaces any previous position.
- R10: When a data write and a control write arrive in the same cycle, the data goes to the newly selected table at the new start index, and the next data write goes to the start index plus one.
- R11: Each read port returns the entry at its address one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word: start index [7:0], selector [11:8] |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 32 | Data word to store |
| noise_raddr | input | 7 | Noise table read address |
| noise_rdata | output | 24 | Noise table read data |
| cfun_raddr | input | 7 | Colour-function table read address |
| cfun_rdata | output | 24 | Colour-function table read data |
| afun_raddr | input | 7 | Alpha-function table read address |
| afun_rdata | output | 24 | Alpha-function table read data |
| color_raddr | input | 8 | Colour table read address |
| color_rdata | output | 32 | Colour table read data |
| cdiff_raddr | input | 8 | Colour-difference table read address |
| cdiff_rdata | output | 32 | Colour-difference table read data |

## Verification
Streams of distinct words are written into every table and read back. This shows whether the selector decode and the index increment place each word in the right memory and the right entry. Words with non-zero top bytes tell whether the 24-bit tables truncate correctly and the 32-bit tables keep every byte. Start indices close to 127 and 255, and one start index with bit 7 set on a 128-entry table, separate correct wrapping from overflow into the wrong entries. Three more cases each test one ordering rule: a reload in the middle of a stream, a control write in the same cycle as a data write, and streams under unused selector codes checked against known contents in all five tables.

// File: rtl/lut_loader_pkg.sv
// Package lut_loader_pkg
// Shared constants and selector decoding for the table loader.
// Assumes the control word layout: start index [7:0], selector [11:8].
package lut_loader_pkg;

    localparam int IDX_W     = 8;
    localparam int SEL_W     = 4;
    localparam int N_TABLES  = 5;
    localparam int DATA_W    = 32;

    // Selector codes of the five tables
    typedef enum logic [SEL_W-1:0] {
        SEL_NOISE = 4'd0,
        SEL_CFUN  = 4'd2,
        SEL_AFUN  = 4'd3,
        SEL_COLOR = 4'd4,
        SEL_CDIFF = 4'd5
    } tbl_sel_e;

    // Bank slot of each table in the one-hot write vector
    localparam int SLOT_NOISE = 0;
    localparam int SLOT_CFUN  = 1;
    localparam int SLOT_AFUN  = 2;
    localparam int SLOT_COLOR = 3;
    localparam int SLOT_CDIFF = 4;

    // True when the selector names one of the short (128-entry) tables
    function automatic logic sel_is_short(input logic [SEL_W-1:0] s);
        return (s == SEL_NOISE) || (s == SEL_CFUN) || (s == SEL_AFUN);
    endfunction

endpackage

// File: rtl/lut_cursor.sv
// Module lut_cursor
// Holds the selected table and the running write index. A control write
// loads both. A data write uses the current state, or the just-written
// control values when both strobes arrive in the same cycle, and then
// advances the index, wrapping at the selected table's depth.
// Assumes SHORT_DEPTH is a power of two no larger than 2**IDX_W.
module lut_cursor
    import lut_loader_pkg::*;
#(
    parameter int SHORT_DEPTH = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [IDX_W-1:0]    ctl_idx,
    input  logic [SEL_W-1:0]    ctl_sel,
    input  logic                dat_we,
    output logic                wr_valid,
    output logic [SEL_W-1:0]    wr_sel,
    output logic [IDX_W-1:0]    wr_idx
);

    localparam logic [IDX_W-1:0] SHORT_MASK = IDX_W'(SHORT_DEPTH - 1);

    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] idx_q;
    logic [SEL_W-1:0] eff_sel;
    logic [IDX_W-1:0] eff_idx;
    logic [IDX_W-1:0] inc_idx;
    logic [IDX_W-1:0] nxt_idx;

    // Pick the state the current data write uses: control values take priority
    always_comb begin
        eff_sel = ctl_we ? ctl_sel : sel_q;
        eff_idx = ctl_we ? ctl_idx : idx_q;
    end

    // Next index after a data write, wrapped at the table depth
    always_comb begin
        inc_idx = eff_idx + IDX_W'(1);
        nxt_idx = sel_is_short(eff_sel) ? (inc_idx & SHORT_MASK) : inc_idx;
    end

    // Update the selector and the running index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            idx_q <= '0;
        end else begin
            sel_q <= eff_sel;
            if (dat_we)
                idx_q <= nxt_idx;
            else if (ctl_we)
                idx_q <= ctl_idx;
        end
    end

    assign wr_valid = dat_we;
    assign wr_sel   = eff_sel;
    assign wr_idx   = eff_idx;

    AST_IDX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !dat_we) |=> (idx_q == $past(ctl_idx))); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && !dat_we) |=> ($stable(idx_q) && $stable(sel_q))); // R4
    AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && sel_is_short(eff_sel)) |=> (idx_q < IDX_W'(SHORT_DEPTH))); // R7
    AST_INVALID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !ctl_we && !sel_is_short(sel_q)) |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R8
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && ctl_we && !sel_is_short(ctl_sel)) |=> (idx_q == $past(ctl_idx) + IDX_W'(1))); // R10

endmodule

// File: rtl/lut_decode.sv
// Module lut_decode
// Turns a data write and its selector into a one-hot bank write vector.
// Unused selector codes produce no write strobe.
// Assumes the slot order defined in lut_loader_pkg.
module lut_decode
    import lut_loader_pkg::*;
(
    input  logic                 wr_valid,
    input  logic [SEL_W-1:0]     wr_sel,
    output logic [N_TABLES-1:0]  bank_we
);

    // Map the selector code to one bank strobe
    always_comb begin
        bank_we = '0;
        if (wr_valid) begin
            unique case (wr_sel)
                SEL_NOISE: bank_we[SLOT_NOISE] = 1'b1;
                SEL_CFUN:  bank_we[SLOT_CFUN]  = 1'b1;
                SEL_AFUN:  bank_we[SLOT_AFUN]  = 1'b1;
                SEL_COLOR: bank_we[SLOT_COLOR] = 1'b1;
                SEL_CDIFF: bank_we[SLOT_CDIFF] = 1'b1;
                default:   bank_we = '0;
            endcase
        end
    end

    always_comb begin
        AST_ONE_BANK: assert ($onehot0(bank_we)); // R3
        if (!wr_valid) AST_IDLE_NO_WE: assert (bank_we == '0); // R8
    end

endmodule

// File: rtl/lut_bank.sv
// Module lut_bank
// One table memory with a write port and a registered read port.
// A read returns the old contents if the same entry is written in the same cycle.
// Assumes DEPTH is a power of two.
module lut_bank #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one entry on a write strobe
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Register the read data for the datapath
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/lut_loader.sv
// Module lut_loader
// Loads five lookup tables through one streaming data port. A control
// write selects a table and a start index; every data write stores one
// word there and advances the index. Each table has its own read port.
// Assumes SHORT_W <= 32 and WIDE_W == 32; bus logic lies outside the block.
module lut_loader
    import lut_loader_pkg::*;
#(
    parameter int SHORT_DEPTH = 128,
    parameter int SHORT_W     = 24,
    parameter int WIDE_DEPTH  = 256,
    parameter int WIDE_W      = 32,
    localparam int SAW        = $clog2(SHORT_DEPTH),
    localparam int WAW        = $clog2(WIDE_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [DATA_W-1:0]   ctl_wdata,
    input  logic                dat_we,
    input  logic [DATA_W-1:0]   dat_wdata,
    input  logic [SAW-1:0]      noise_raddr,
    output logic [SHORT_W-1:0]  noise_rdata,
    input  logic [SAW-1:0]      cfun_raddr,
    output logic [SHORT_W-1:0]  cfun_rdata,
    input  logic [SAW-1:0]      afun_raddr,
    output logic [SHORT_W-1:0]  afun_rdata,
    input  logic [WAW-1:0]      color_raddr,
    output logic [WIDE_W-1:0]   color_rdata,
    input  logic [WAW-1:0]      cdiff_raddr,
    output logic [WIDE_W-1:0]   cdiff_rdata
);

    localparam int N_SHORT = 3;
    localparam int N_WIDE  = N_TABLES - N_SHORT;

    logic                 wr_valid;
    logic [SEL_W-1:0]     wr_sel;
    logic [IDX_W-1:0]     wr_idx;
    logic [N_TABLES-1:0]  bank_we;
    logic [SAW-1:0]       s_raddr [N_SHORT];
    logic [SHORT_W-1:0]   s_rdata [N_SHORT];
    logic [WAW-1:0]       w_raddr [N_WIDE];
    logic [WIDE_W-1:0]    w_rdata [N_WIDE];
    logic                 unused_ctl_bits;

    assign unused_ctl_bits = ^ctl_wdata[DATA_W-1:IDX_W+SEL_W];

    lut_cursor #(.SHORT_DEPTH(SHORT_DEPTH)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_idx  (ctl_wdata[IDX_W-1:0]),
        .ctl_sel  (ctl_wdata[IDX_W+SEL_W-1:IDX_W]),
        .dat_we   (dat_we),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_idx   (wr_idx)
    );

    lut_decode u_decode (
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .bank_we  (bank_we)
    );

    // Map the short-table read ports to the bank array
    always_comb begin
        s_raddr[SLOT_NOISE] = noise_raddr;
        s_raddr[SLOT_CFUN]  = cfun_raddr;
        s_raddr[SLOT_AFUN]  = afun_raddr;
        w_raddr[SLOT_COLOR - N_SHORT] = color_raddr;
        w_raddr[SLOT_CDIFF - N_SHORT] = cdiff_raddr;
    end

    assign noise_rdata = s_rdata[SLOT_NOISE];
    assign cfun_rdata  = s_rdata[SLOT_CFUN];
    assign afun_rdata  = s_rdata[SLOT_AFUN];
    assign color_rdata = w_rdata[SLOT_COLOR - N_SHORT];
    assign cdiff_rdata = w_rdata[SLOT_CDIFF - N_SHORT];

    for (genvar g = 0; g < N_SHORT; g++) begin : g_short
        lut_bank #(.DEPTH(SHORT_DEPTH), .WIDTH(SHORT_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .waddr (wr_idx[SAW-1:0]),
            .wdata (dat_wdata[SHORT_W-1:0]),
            .raddr (s_raddr[g]),
            .rdata (s_rdata[g])
        );
    end

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        lut_bank #(.DEPTH(WIDE_DEPTH), .WIDTH(WIDE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[N_SHORT + g]),
            .waddr (wr_idx[WAW-1:0]),
            .wdata (dat_wdata[WIDE_W-1:0]),
            .raddr (w_raddr[g]),
            .rdata (w_rdata[g])
        );
    end

    AST_WE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != '0) |-> dat_we); // R4
    AST_NOISE_ON_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && ctl_we && ctl_wdata[11:8] == 4'd0) |-> bank_we[SLOT_NOISE]); // R10

endmodule

// File: tb/test_lut_loader.sv
module test_lut_loader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic        dat_we;
    logic [31:0] dat_wdata;
    logic [6:0]  noise_raddr, cfun_raddr, afun_raddr;
    logic [23:0] noise_rdata, cfun_rdata, afun_rdata;
    logic [7:0]  color_raddr, cdiff_raddr;
    logic [31:0] color_rdata, cdiff_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    lut_loader i_lut_loader (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .noise_raddr(noise_raddr), .noise_rdata(noise_rdata),
        .cfun_raddr(cfun_raddr), .cfun_rdata(cfun_rdata),
        .afun_raddr(afun_raddr), .afun_rdata(afun_rdata),
        .color_raddr(color_raddr), .color_rdata(color_rdata),
        .cdiff_raddr(cdiff_raddr), .cdiff_rdata(cdiff_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ctl_write(input logic [3:0] sel, input logic [7:0] idx);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {20'hA5A5A, sel, idx};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic dat_write(input logic [31:0] d);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    // table: 0 noise,1 cfun,2 afun,3 color,4 cdiff
    task automatic rd(input int tbl, input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        noise_raddr = a[6:0]; cfun_raddr = a[6:0]; afun_raddr = a[6:0];
        color_raddr = a; cdiff_raddr = a;
        @(negedge clk);
        case (tbl)
            0: v = {8'h0, noise_rdata};
            1: v = {8'h0, cfun_rdata};
            2: v = {8'h0, afun_rdata};
            3: v = color_rdata;
            default: v = cdiff_rdata;
        endcase
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 8'd0, v);
        check("R1 rdata after reset", noise_rdata, 32'h0);
        dat_write(32'hFF00_0011);
        rd(0, 8'd0, v);
        check("R1 first write to noise[0]", v, 32'h0000_0011);
    endtask

    task automatic t_wide_fields();
        logic [31:0] v;
        ctl_write(4'd4, 8'd5);
        dat_write(32'h4433_2211);
        rd(3, 8'd5, v);
        check("R2 R6 color[5] full word", v, 32'h4433_2211);
        check("R6 red in low byte", {24'h0, v[7:0]}, 32'h11);
        ctl_write(4'd5, 8'd9);
        dat_write(32'h80FF_7F01);
        rd(4, 8'd9, v);
        check("R3 R6 cdiff[9]", v, 32'h80FF_7F01);
        rd(3, 8'd9, v);
        check("R3 color[9] untouched", v === 32'h80FF_7F01 ? 32'h1 : 32'h0, 32'h0);
    endtask

    task automatic t_stream_short();
        logic [31:0] v;
        ctl_write(4'd2, 8'd10);
        for (int i = 0; i < 3; i++) dat_write(32'hAB00_0100 + i);
        for (int i = 0; i < 3; i++) begin
            rd(1, 8'(10 + i), v);
            check("R4 R5 cfun stream", v, 32'h0000_0100 + i);
        end
        ctl_write(4'd3, 8'd0);
        dat_write(32'hFF12_3456);
        rd(2, 8'd0, v);
        check("R3 R5 afun[0] truncated", v, 32'h0012_3456);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        ctl_write(4'd0, 8'd126);
        for (int i = 0; i < 3; i++) dat_write(32'h0000_0A00 + i);
        rd(0, 8'd126, v); check("R7 noise[126]", v, 32'h0A00);
        rd(0, 8'd127, v); check("R7 noise[127]", v, 32'h0A01);
        rd(0, 8'd0,   v); check("R7 noise wraps to 0", v, 32'h0A02);
        ctl_write(4'd5, 8'd254);
        for (int i = 0; i < 3; i++) dat_write(32'hC000_0000 + i);
        rd(4, 8'd254, v); check("R7 cdiff[254]", v, 32'hC000_0000);
        rd(4, 8'd255, v); check("R7 cdiff[255]", v, 32'hC000_0001);
        rd(4, 8'd0,   v); check("R7 cdiff wraps to 0", v, 32'hC000_0002);
        ctl_write(4'd0, 8'h85);
        dat_write(32'h0000_0B05);
        rd(0, 8'd5, v); check("R7 start 0x85 lands at noise[5]", v, 32'h0B05);
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        for (int t = 0; t < 5; t++) begin
            ctl_write(t == 0 ? 4'd0 : 4'(t + 1), 8'd40);
            dat_write(32'h0055_0000 + t);
        end
        ctl_write(4'd1, 8'd40);
        for (int i = 0; i < 4; i++) dat_write(32'hDEAD_BEEF);
        ctl_write(4'd6, 8'd40);
        dat_write(32'hDEAD_BEEF);
        ctl_write(4'd15, 8'd39);
        for (int i = 0; i < 3; i++) dat_write(32'hDEAD_BEEF);
        for (int t = 0; t < 5; t++) begin
            rd(t, 8'd40, v);
            check("R8 table unchanged by invalid selector", v, 32'h0055_0000 + t);
        end
    endtask

    task automatic t_reload();
        logic [31:0] v;
        ctl_write(4'd4, 8'd100);
        dat_write(32'h1111_1111);
        ctl_write(4'd4, 8'd20);
        dat_write(32'h2222_2222);
        rd(3, 8'd20, v);  check("R9 reload writes color[20]", v, 32'h2222_2222);
        rd(3, 8'd100, v); check("R9 color[100] keeps first word", v, 32'h1111_1111);
        rd(3, 8'd101, v); check("R9 color[101] not written", v === 32'h2222_2222 ? 32'h1 : 32'h0, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        ctl_write(4'd4, 8'd200);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {20'h0, 4'd0, 8'd60};
        dat_we = 1'b1; dat_wdata = 32'h0000_0777;
        @(negedge clk);
        ctl_we = 1'b0; dat_wdata = 32'h0000_0888;
        @(negedge clk);
        dat_we = 1'b0;
        rd(0, 8'd60, v); check("R10 same-cycle data at new start", v, 32'h0777);
        rd(0, 8'd61, v); check("R10 next data at start+1", v, 32'h0888);
        rd(3, 8'd200, v); check("R10 old table not written", v === 32'h0777 ? 32'h1 : 32'h0, 32'h0);
    endtask

    task automatic t_read_latency();
        @(negedge clk);
        noise_raddr = 7'd60;
        @(posedge clk); #1;
        check("R11 data one clock after address", {8'h0, noise_rdata}, 32'h0777);
        @(negedge clk);
        noise_raddr = 7'd61;
        #1;
        check("R11 output holds until next edge", {8'h0, noise_rdata}, 32'h0777);
        @(posedge clk); #1;
        check("R11 new address after edge", {8'h0, noise_rdata}, 32'h0888);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_we = 1'b0; dat_we = 1'b0;
        ctl_wdata = '0; dat_wdata = '0;
        noise_raddr = '0; cfun_raddr = '0; afun_raddr = '0;
        color_raddr = '0; cdiff_raddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_fields();
        t_stream_short();
        t_wrap();
        t_invalid();
        t_reload();
        t_same_cycle();
        t_read_latency();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule